// File: doc/BRIEF.md
# Tile configuration register unit

This unit holds the shape of a bank of eight two-dimensional tile registers. Software writes a 64-byte configuration image into it one byte per cycle. The unit checks the image while the bytes arrive. When the last byte is accepted, it either commits the whole image or raises a one-cycle fault and keeps the configuration it already had.

The image carries several fields:
- a palette id;
- a start-row value;
- for each tile, a 16-bit count of bytes per row, written least significant byte first;
- for each tile, an 8-bit row count;
- several reserved regions, which must all be zero.

Palette 1 selects the active layout. Palette 0 returns the unit to its init state. In the init state every tile is unconfigured, and a zero-data request is pulsed so that the separate tile storage clears itself. A release command has the same effect at any time.

A readback command streams the committed image out as 64 bytes. While the unit is unconfigured, the readback returns all zeros. Each tile's row count, bytes-per-row value and configured flag are presented on flat output vectors for the datapath.

Top module: `tile_cfg_unit`

## Requirements
- R1: After reset the unit is unconfigured: `cfg_active` is 0, every `tile_valid` bit is 0, every row count and bytes-per-row field is 0, and `rd_valid`, `load_done`, `load_fault` and `zero_req` are 0.
- R2: Each cycle with `wr_valid` high accepts one image byte, starting at index 0 and ending at index 63. The layout is:
  - byte 0 is the palette;
  - byte 1 is the start row;
  - bytes 16+2t (low) and 17+2t (high) are the bytes-per-row of tile t;
  - byte 48+t is the row count of tile t.

  For tile t, `tile_rows[8t+7:8t]` and `tile_colsb[16t+15:16t]` carry the committed values. On a valid commit, `load_done` is high and the new values show in the cycle after the edge that accepted byte 63.
- R3: A nonzero byte at any reserved index (2..15, 32..47, 56..63) makes the image invalid.
- R4: A palette value above 1 makes the image invalid.
- R5: With palette 1, a bytes-per-row value above `MAX_COLSB` (default 64) or a row count above `MAX_ROWS` (default 16) makes the image invalid. The values 64 and 16 exactly are accepted.
- R6: A valid image with palette 0 returns the unit to the init state, whatever its other field values are. In the following cycle both `load_done` and `zero_req` are high.
- R7: For an invalid image, `load_fault` is high for exactly one cycle, `load_done` stays low, and the previous configuration is kept unchanged.
- R8: `release_req` returns the unit to the init state and pulses `zero_req` in the next cycle. It also discards any partly received image, so the next accepted byte is index 0 again.
- R9: A `rd_start` pulse while idle produces 64 consecutive cycles of `rd_valid`, with `rd_byte` giving image bytes 0..63 in order. After a valid palette-1 load, these are exactly the loaded bytes. While the unit is unconfigured, all 64 bytes are zero.
- R10: `tile_valid[t]` is 1 only when the palette is 1 and tile t has a nonzero row count and a nonzero bytes-per-row value.
- R11: A `rd_start` that arrives during a readback is ignored: the stream stays exactly 64 bytes long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Image byte present |
| wr_byte | input | 8 | Image byte |
| release_req | input | 1 | Return to init state, abort partial load |
| rd_start | input | 1 | Start a 64-byte readback |
| rd_valid | output | 1 | Readback byte present |
| rd_byte | output | 8 | Readback byte |
| load_done | output | 1 | One-cycle pulse: image committed |
| load_fault | output | 1 | One-cycle pulse: image rejected |
| zero_req | output | 1 | One-cycle pulse: clear all tile data |
| cfg_active | output | 1 | Palette 1 configuration in effect |
| cfg_start_row | output | 8 | Committed start row |
| tile_valid | output | 8 | Per-tile configured flag |
| tile_rows | output | 64 | Per-tile row count, 8 bits each |
| tile_colsb | output | 128 | Per-tile bytes per row, 16 bits each |

## Verification
The bench targets the following cases:
- **Limit boundaries.** It loads images at exactly 64 bytes per row and 16 rows, and one step beyond each. An off-by-one in the comparison would either reject the legal maximum or let an oversized tile through.
- **Rejected images.** It places a nonzero value in a reserved byte and uses a palette of 2. It then reads the configuration back. A design that commits staging data before its checks finish would show the rejected image in place of the prior one.
- **Palette-0 image with nonzero fields.** This must still produce all-zero readback. A design that stored those fields would leak them.
- **Release mid-image, then a full image.** The full image must commit cleanly. A byte counter that was not reset would misalign every field.
- **Second start during readback.** The stream must stay 64 bytes long. A design that restarted would emit extra bytes.

// File: rtl/tile_cfg_unit.sv
module tile_cfg_unit #(
  parameter int MAX_COLSB = 64,
  parameter int MAX_ROWS  = 16,
  localparam int NT       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [7:0]       wr_byte,
  input  logic             release_req,
  input  logic             rd_start,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             load_done,
  output logic             load_fault,
  output logic             zero_req,
  output logic             cfg_active,
  output logic [7:0]       cfg_start_row,
  output logic [NT-1:0]    tile_valid,
  output logic [NT*8-1:0]  tile_rows,
  output logic [NT*16-1:0] tile_colsb
);
  localparam int IMG_BYTES = 64;
  localparam int IW = $clog2(IMG_BYTES);
  localparam logic [IW-1:0] LAST_IDX = IW'(IMG_BYTES - 1);
  localparam logic [15:0] COLSB_LIM = 16'(MAX_COLSB);
  localparam logic [7:0]  ROWS_LIM  = 8'(MAX_ROWS);

  logic [IW-1:0] wr_idx;
  logic          bad_acc;
  logic [7:0]    st_pal, st_srow;
  logic [15:0]   st_colsb [NT];
  logic [7:0]    st_rows  [NT];

  logic          c_active;
  logic [7:0]    c_srow;
  logic [15:0]   c_colsb [NT];
  logic [7:0]    c_rows  [NT];

  logic          rd_active;
  logic [IW-1:0] rd_idx;

  logic wr_res, wr_colsb, wr_rows, last_byte, limit_bad, img_bad;
  logic finish, commit_cfg, go_init;

  assign wr_res = (wr_idx >= IW'(2)  && wr_idx < IW'(16)) ||
                  (wr_idx >= IW'(32) && wr_idx < IW'(48)) ||
                  (wr_idx >= IW'(56));
  assign wr_colsb  = wr_idx >= IW'(16) && wr_idx < IW'(32);
  assign wr_rows   = wr_idx >= IW'(48) && wr_idx < IW'(56);
  assign last_byte = wr_idx == LAST_IDX;

  always_comb begin
    limit_bad = 1'b0;
    for (int t = 0; t < NT; t++)
      if (st_colsb[t] > COLSB_LIM || st_rows[t] > ROWS_LIM) limit_bad = 1'b1;
  end

  assign img_bad    = bad_acc || (wr_byte != 8'd0) || (st_pal > 8'd1) ||
                      (st_pal == 8'd1 && limit_bad);
  assign finish     = wr_valid && last_byte && !release_req;
  assign commit_cfg = finish && !img_bad && st_pal == 8'd1;
  assign go_init    = release_req || (finish && !img_bad && st_pal == 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      bad_acc <= 1'b0;
      st_pal  <= '0;
      st_srow <= '0;
      for (int t = 0; t < NT; t++) begin
        st_colsb[t] <= '0;
        st_rows[t]  <= '0;
      end
    end else if (release_req) begin
      wr_idx  <= '0;
      bad_acc <= 1'b0;
    end else if (wr_valid) begin
      wr_idx  <= wr_idx + IW'(1);
      bad_acc <= last_byte ? 1'b0 : (bad_acc || (wr_res && wr_byte != 8'd0));
      if (wr_idx == IW'(0)) st_pal  <= wr_byte;
      if (wr_idx == IW'(1)) st_srow <= wr_byte;
      if (wr_colsb) begin
        if (wr_idx[0]) st_colsb[wr_idx[3:1]][15:8] <= wr_byte;
        else           st_colsb[wr_idx[3:1]][7:0]  <= wr_byte;
      end
      if (wr_rows) st_rows[wr_idx[2:0]] <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || go_init) begin
      c_active <= 1'b0;
      c_srow   <= '0;
      for (int t = 0; t < NT; t++) begin
        c_colsb[t] <= '0;
        c_rows[t]  <= '0;
      end
    end else if (commit_cfg) begin
      c_active <= 1'b1;
      c_srow   <= st_srow;
      for (int t = 0; t < NT; t++) begin
        c_colsb[t] <= st_colsb[t];
        c_rows[t]  <= st_rows[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_done  <= 1'b0;
      load_fault <= 1'b0;
      zero_req   <= 1'b0;
    end else begin
      load_done  <= finish && !img_bad;
      load_fault <= finish && img_bad;
      zero_req   <= go_init;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_idx    <= '0;
    end else if (!rd_active) begin
      rd_active <= rd_start;
      rd_idx    <= '0;
    end else begin
      rd_idx <= rd_idx + IW'(1);
      if (rd_idx == LAST_IDX) rd_active <= 1'b0;
    end
  end

  always_comb begin
    rd_byte = 8'd0;
    if (rd_active) begin
      if (rd_idx == IW'(0))
        rd_byte = {7'd0, c_active};
      else if (rd_idx == IW'(1))
        rd_byte = c_srow;
      else if (rd_idx >= IW'(16) && rd_idx < IW'(32))
        rd_byte = rd_idx[0] ? c_colsb[rd_idx[3:1]][15:8] : c_colsb[rd_idx[3:1]][7:0];
      else if (rd_idx >= IW'(48) && rd_idx < IW'(56))
        rd_byte = c_rows[rd_idx[2:0]];
    end
  end

  assign rd_valid      = rd_active;
  assign cfg_active    = c_active;
  assign cfg_start_row = c_srow;

  for (genvar t = 0; t < NT; t++) begin : g_tile
    assign tile_rows[8*t +: 8]   = c_rows[t];
    assign tile_colsb[16*t +: 16] = c_colsb[t];
    assign tile_valid[t] = c_active && c_rows[t] != 8'd0 && c_colsb[t] != 16'd0;
  end
endmodule

// File: rtl/tile_cfg_unit_chk.sv
module tile_cfg_unit_chk #(
  parameter int MAX_COLSB = 64,
  parameter int MAX_ROWS  = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         release_req,
  input logic         load_done,
  input logic         load_fault,
  input logic         zero_req,
  input logic         cfg_active,
  input logic [7:0]   tile_valid,
  input logic [63:0]  tile_rows,
  input logic [127:0] tile_colsb
);
  assert_done_xor_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && load_fault)) else $error("done and fault together");

  assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fault |=> !load_fault) else $error("fault longer than one cycle");

  assert_fault_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fault |-> ($stable(tile_rows) && $stable(tile_colsb) && $stable(cfg_active)))
    else $error("configuration changed on fault");

  assert_init_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |-> (tile_valid == 8'd0 && !cfg_active)) else $error("init left tiles configured");

  assert_release_inits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |=> zero_req) else $error("release without zero request");

  assert_valid_needs_palette_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid != 8'd0) |-> cfg_active) else $error("tile flagged without palette 1");

  for (genvar t = 0; t < 8; t++) begin : g_lim
    assert_tile_limits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_active |-> (tile_rows[8*t +: 8] <= 8'(MAX_ROWS) &&
                      tile_colsb[16*t +: 16] <= 16'(MAX_COLSB)))
      else $error("committed tile exceeds limits");
  end
endmodule

bind tile_cfg_unit tile_cfg_unit_chk #(.MAX_COLSB(MAX_COLSB), .MAX_ROWS(MAX_ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .release_req(release_req), .load_done(load_done),
  .load_fault(load_fault), .zero_req(zero_req), .cfg_active(cfg_active),
  .tile_valid(tile_valid), .tile_rows(tile_rows), .tile_colsb(tile_colsb)
);

// File: tb/tile_cfg_unit_tb_top.sv
`timescale 1ns/1ps
module tile_cfg_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, release_req = 1'b0, rd_start = 1'b0;
  logic [7:0] wr_byte = 8'd0;
  logic rd_valid, load_done, load_fault, zero_req, cfg_active;
  logic [7:0] rd_byte, cfg_start_row, tile_valid;
  logic [63:0] tile_rows;
  logic [127:0] tile_colsb;

  int compared = 0, mismatched = 0;
  logic [7:0] img [64];
  logic [7:0] exp_img [64];
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  tile_cfg_unit dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    compared++;
    if (exp_q.size() == 0) begin
      mismatched++;
      $display("FAIL R11 extra readback byte actual=%0h expected=none", rd_byte);
    end else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      if (rd_byte !== e) begin
        mismatched++;
        $display("FAIL R9 readback actual=%0h expected=%0h", rd_byte, e);
      end
    end
  end

  task automatic clear_img(logic [7:0] pal, logic [7:0] srow);
    for (int i = 0; i < 64; i++) img[i] = 8'd0;
    img[0] = pal; img[1] = srow;
  endtask

  task automatic set_tile(int t, logic [15:0] cb, logic [7:0] rw);
    img[16+2*t] = cb[7:0]; img[17+2*t] = cb[15:8]; img[48+t] = rw;
  endtask

  task automatic accept_img();
    for (int i = 0; i < 64; i++) exp_img[i] = img[i];
  endtask

  task automatic zero_exp();
    for (int i = 0; i < 64; i++) exp_img[i] = 8'd0;
  endtask

  task automatic send_img();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); wr_valid = 1'b1; wr_byte = img[i];
    end
    @(negedge clk); wr_valid = 1'b0; wr_byte = 8'd0;
  endtask

  task automatic chk_tiles(string tag);
    chk({tag, " active"}, {31'd0, cfg_active}, {31'd0, exp_img[0] == 8'd1});
    chk({tag, " start_row"}, {24'd0, cfg_start_row}, {24'd0, exp_img[1]});
    for (int t = 0; t < 8; t++) begin
      logic [15:0] cb;
      logic [7:0] rw;
      cb = {exp_img[17+2*t], exp_img[16+2*t]};
      rw = exp_img[48+t];
      chk({tag, " rows"}, {24'd0, tile_rows[8*t +: 8]}, {24'd0, rw});
      chk({tag, " colsb"}, {16'd0, tile_colsb[16*t +: 16]}, {16'd0, cb});
      chk({tag, " R10 tile_valid"}, {31'd0, tile_valid[t]},
          {31'd0, exp_img[0] == 8'd1 && rw != 8'd0 && cb != 16'd0});
    end
  endtask

  task automatic readback();
    for (int i = 0; i < 64; i++) exp_q.push_back(exp_img[i]);
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    repeat (66) @(negedge clk);
    chk("R9 readback drained", exp_q.size(), 0);
  endtask

  task automatic expect_fault(string tag);
    send_img();
    chk({tag, " fault"}, {31'd0, load_fault}, 32'd1);
    chk({tag, " no done"}, {31'd0, load_done}, 32'd0);
    @(negedge clk);
    chk("R7 fault one cycle", {31'd0, load_fault}, 32'd0);
    chk_tiles({tag, " R7 kept"});
  endtask

  initial begin
    zero_exp();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 flags", {29'd0, load_done, load_fault, zero_req}, 32'd0);
    chk_tiles("R1 reset");
    readback();

    clear_img(8'd1, 8'd3);
    for (int t = 0; t < 8; t++) set_tile(t, 16'(8*(t+1)), 8'(2*t));
    send_img();
    chk("R2 done", {31'd0, load_done}, 32'd1);
    chk("R2 no fault", {31'd0, load_fault}, 32'd0);
    accept_img();
    chk_tiles("R2 image A");
    readback();

    clear_img(8'd1, 8'd5);
    for (int t = 0; t < 8; t++) set_tile(t, 16'd64, 8'd16);
    send_img();
    chk("R5 max accepted", {31'd0, load_done}, 32'd1);
    accept_img();
    chk_tiles("R5 image B");

    set_tile(3, 16'd65, 8'd16);
    expect_fault("R5 colsb 65");
    set_tile(3, 16'd64, 8'd17);
    expect_fault("R5 rows 17");
    set_tile(3, 16'd64, 8'd16);
    img[40] = 8'h01;
    expect_fault("R3 reserved byte");
    img[40] = 8'h00;
    img[0] = 8'd2;
    expect_fault("R4 palette 2");
    readback();

    clear_img(8'd0, 8'd7);
    for (int t = 0; t < 8; t++) set_tile(t, 16'd32, 8'd4);
    send_img();
    chk("R6 done", {31'd0, load_done}, 32'd1);
    chk("R6 zero_req", {31'd0, zero_req}, 32'd1);
    zero_exp();
    chk_tiles("R6 init");
    readback();

    clear_img(8'd1, 8'd3);
    for (int t = 0; t < 8; t++) set_tile(t, 16'(8*(t+1)), 8'(2*t));
    send_img();
    accept_img();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); wr_valid = 1'b1; wr_byte = 8'hA5;
    end
    @(negedge clk); wr_valid = 1'b0; release_req = 1'b1;
    @(negedge clk); release_req = 1'b0;
    chk("R8 zero_req", {31'd0, zero_req}, 32'd1);
    zero_exp();
    chk_tiles("R8 released");
    clear_img(8'd1, 8'd9);
    for (int t = 0; t < 8; t++) set_tile(t, 16'd16, 8'(t + 1));
    send_img();
    chk("R8 realigned done", {31'd0, load_done}, 32'd1);
    accept_img();
    chk_tiles("R8 after release");

    for (int i = 0; i < 64; i++) exp_q.push_back(exp_img[i]);
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    repeat (10) @(negedge clk);
    rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    repeat (60) @(negedge clk);
    chk("R11 single stream", exp_q.size(), 0);
    chk("R11 idle after", {31'd0, rd_valid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule